// File: doc/BRIEF.md
# Load-Reserved Reservation Monitor

This block sits beside one core and tracks a single load-reserved / store-conditional reservation. A load-reserved request records the granule that holds its address. Each later store-conditional is answered in the same cycle with a pass or a fail. A pass means the core may perform the write. A fail means it must not.

Several events end the reservation:
- a local store into the granule, when that option is enabled;
- a snooped remote store or invalidation that hits the reserved cache line;
- a trap taken by the core;
- the eviction or refill of the reserved line.

A snooped remote load-reserved never disturbs the local reservation.

Two cores can contend for the same line. To stop them from stealing it from each other forever, a remote invalidation that hits the line soon after the local load-reserved is not applied at once. It is parked for a fixed number of cycles, and `snpStall` tells the coherence side that its request is being held back. When the window closes, the parked invalidation takes effect straight away.

The core issues at most one of load-reserved, store-conditional and local store in any cycle. Snoop, trap and eviction inputs are independent of those requests and of each other.

Top module: `resv_monitor`

## Requirements
- R1: A load-reserved (`lrValid`) arms the reservation on the granule `lrAddr >> GRAN_LG`. A later load-reserved replaces any earlier reservation and drops any parked invalidation.
- R2: `scPass` is high in the cycle of a store-conditional only when all three hold: the reservation is armed, `scAddr` lies in the reserved granule, and no clearing event arrives in that same cycle. In every other case it is low.
- R3: Every store-conditional ends the reservation, whether it passes or fails.
- R4: Once the deferral window has closed, a snoop with `snpInv`=1 whose address lies in the reserved line (`addr >> LINE_LG`) clears the reservation. A store-conditional in that same cycle fails. Snoops to other lines have no effect.
- R5: A snoop with `snpInv`=0 (a remote load-reserved) never clears the reservation.
- R6: With `LOCAL_ST_CLR`=1, a local store into the reserved granule clears the reservation. A local store outside the granule has no effect.
- R7: A trap clears the reservation. A load-reserved in the same cycle as a trap does not arm.
- R8: An eviction of the reserved line clears the reservation. An eviction of another line has no effect.
- R9: For `DEFER_CYCLES` cycles after a load-reserved, a hitting snoop with `snpInv`=1 is parked instead of applied. The reservation survives, and `snpStall` goes high from the next cycle.
- R10: In the first cycle after the window closes, a parked invalidation clears the reservation, so a store-conditional there fails, and `snpStall` falls on the following cycle. A snoop parked in the first window cycle keeps `snpStall` high for exactly `DEFER_CYCLES` cycles.
- R11: Reset clears the reservation and any parked invalidation. After reset, `snpStall` is low and a store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lrValid | input | 1 | Load-reserved request |
| lrAddr | input | ADDR_W | Load-reserved address |
| scValid | input | 1 | Store-conditional request |
| scAddr | input | ADDR_W | Store-conditional address |
| scPass | output | 1 | Store-conditional may write (same cycle) |
| stValid | input | 1 | Ordinary local store |
| stAddr | input | ADDR_W | Local store address |
| snpValid | input | 1 | Snooped remote request |
| snpInv | input | 1 | 1 = remote store/invalidation, 0 = remote load-reserved |
| snpAddr | input | ADDR_W | Snoop address |
| snpStall | output | 1 | A hitting invalidation is being held back |
| trapValid | input | 1 | Exception or trap taken by the core |
| evictValid | input | 1 | Cache line evicted or refilled |
| evictAddr | input | ADDR_W | Address of the evicted line |

## Verification
The embedded assertions check the following on every cycle:
- each store-conditional, trap and window-closed remote hit leaves the reservation cleared;
- a hit inside the window leaves it armed with the invalidation parked;
- a parked invalidation is released once the window closes;
- a remote load-reserved leaves the reservation alone;
- arming opens the window.

Only the bench scenarios can show the following:
- whether the granule and line comparisons pick the right addresses;
- the exact number of stall cycles;
- that a store-conditional inside the window still passes;
- that a load-reserved cancelled by a trap never arms.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic arm;   // capture a new granule, restart the deferral window
    logic drop;  // forget the reservation, close the window
  } resvCmd_t;
endpackage

// File: rtl/resv_dp.sv
module resv_dp
  import resv_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int GRAN_LG      = 6,
  parameter int LINE_LG      = 6,
  parameter int DEFER_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvCmd_t          cmd,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ADDR_W-1:0] evictAddr,
  output logic              scGran,
  output logic              stGran,
  output logic              snpLine,
  output logic              evictLine,
  output logic              windowOpen
);
  localparam int TAG_W = ADDR_W - GRAN_LG;
  localparam int SHIFT = LINE_LG - GRAN_LG;
  localparam int CNT_W = $clog2(DEFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEFER_CYCLES);

  logic [TAG_W-1:0] resvTag;
  logic [TAG_W-1:0] lineTag;
  logic [CNT_W-1:0] deferCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resvTag <= '0;
    else if (cmd.arm) resvTag <= TAG_W'(lrAddr >> GRAN_LG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deferCnt <= '0;
    else if (cmd.arm) deferCnt <= CNT_LOAD;
    else if (cmd.drop) deferCnt <= '0;
    else if (deferCnt != '0) deferCnt <= deferCnt - CNT_W'(1);
  end

  assign lineTag    = resvTag >> SHIFT;
  assign scGran     = (TAG_W'(scAddr >> GRAN_LG) == resvTag);
  assign stGran     = (TAG_W'(stAddr >> GRAN_LG) == resvTag);
  assign snpLine    = (TAG_W'(snpAddr >> LINE_LG) == lineTag);
  assign evictLine  = (TAG_W'(evictAddr >> LINE_LG) == lineTag);
  assign windowOpen = (deferCnt != '0);

  AST_ARM_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    cmd.arm |=> windowOpen); // R9
  AST_DROP_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.drop && !cmd.arm) |=> !windowOpen); // R3
endmodule

// File: rtl/resv_ctl.sv
module resv_ctl
  import resv_pkg::*;
#(
  parameter bit LOCAL_ST_CLR = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lrValid,
  input  logic     scValid,
  input  logic     stValid,
  input  logic     snpValid,
  input  logic     snpInv,
  input  logic     trapValid,
  input  logic     evictValid,
  input  logic     scGran,
  input  logic     stGran,
  input  logic     snpLine,
  input  logic     evictLine,
  input  logic     windowOpen,
  output resvCmd_t cmd,
  output logic     scPass,
  output logic     snpStall
);
  logic resvValid;
  logic pendQ;
  logic remoteHit;
  logic stKill;
  logic killNow;

  generate
    if (LOCAL_ST_CLR) begin : g_stClear
      assign stKill = stValid & stGran;
    end else begin : g_stKeep
      assign stKill = stValid & stGran & 1'b0;
    end
  endgenerate

  assign remoteHit = resvValid & snpValid & snpInv & snpLine;
  assign killNow   = resvValid & (trapValid | (evictValid & evictLine) | stKill
                     | (remoteHit & ~windowOpen) | (pendQ & ~windowOpen));
  assign scPass    = scValid & resvValid & scGran & ~killNow;
  assign cmd.arm   = lrValid & ~trapValid;
  assign cmd.drop  = ~cmd.arm & (scValid | killNow | lrValid);
  assign snpStall  = pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      pendQ     <= 1'b0;
    end else if (cmd.arm) begin
      resvValid <= 1'b1;
      pendQ     <= 1'b0;
    end else if (cmd.drop) begin
      resvValid <= 1'b0;
      pendQ     <= 1'b0;
    end else if (remoteHit && windowOpen) begin
      pendQ     <= 1'b1;
    end
  end

  AST_SC_ENDS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !lrValid) |=> !resvValid); // R3
  AST_TRAP_ENDS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !resvValid); // R7
  AST_REMOTE_ENDS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    (remoteHit && !windowOpen && !lrValid) |=> !resvValid); // R4
  AST_DEFER_HOLDS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    (remoteHit && windowOpen && !lrValid && !scValid && !trapValid
     && !(evictValid && evictLine) && !stKill) |=> (resvValid && pendQ)); // R9
  AST_STALL_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !windowOpen) |=> !pendQ); // R10
  AST_REMOTE_LR_HARMLESS: assert property (@(posedge clk) disable iff (!rstN)
    (resvValid && snpValid && !snpInv && !lrValid && !scValid && !stValid
     && !trapValid && !evictValid && !(pendQ && !windowOpen)) |=> resvValid); // R5
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int GRAN_LG      = 6,
  parameter int LINE_LG      = 6,
  parameter int DEFER_CYCLES = 16,
  parameter bit LOCAL_ST_CLR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrValid,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  output logic              scPass,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              snpValid,
  input  logic              snpInv,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpStall,
  input  logic              trapValid,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr
);
  resvCmd_t cmd;
  logic scGran, stGran, snpLine, evictLine, windowOpen;

  resv_ctl #(.LOCAL_ST_CLR(LOCAL_ST_CLR)) u_ctl (
    .clk(clk), .rstN(rstN), .lrValid(lrValid), .scValid(scValid),
    .stValid(stValid), .snpValid(snpValid), .snpInv(snpInv),
    .trapValid(trapValid), .evictValid(evictValid), .scGran(scGran),
    .stGran(stGran), .snpLine(snpLine), .evictLine(evictLine),
    .windowOpen(windowOpen), .cmd(cmd), .scPass(scPass), .snpStall(snpStall)
  );

  resv_dp #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .LINE_LG(LINE_LG),
            .DEFER_CYCLES(DEFER_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lrAddr(lrAddr), .scAddr(scAddr),
    .stAddr(stAddr), .snpAddr(snpAddr), .evictAddr(evictAddr),
    .scGran(scGran), .stGran(stGran), .snpLine(snpLine),
    .evictLine(evictLine), .windowOpen(windowOpen)
  );
endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
  localparam int AW = 32;
  localparam int GL = 4;
  localparam int LL = 6;
  localparam int DEF = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lrValid, scValid, stValid, snpValid, snpInv, trapValid, evictValid;
  logic [AW-1:0] lrAddr, scAddr, stAddr, snpAddr, evictAddr;
  logic scPass, snpStall;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  string curReq = "R11";

  // behavioural reference state
  bit mValid = 0;
  bit mPend = 0;
  int mLeft = 0;
  logic [AW-1:0] mAddr = '0;

  always #10 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .GRAN_LG(GL), .LINE_LG(LL), .DEFER_CYCLES(DEF),
                 .LOCAL_ST_CLR(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .lrValid(lrValid), .lrAddr(lrAddr),
    .scValid(scValid), .scAddr(scAddr), .scPass(scPass), .stValid(stValid),
    .stAddr(stAddr), .snpValid(snpValid), .snpInv(snpInv), .snpAddr(snpAddr),
    .snpStall(snpStall), .trapValid(trapValid), .evictValid(evictValid),
    .evictAddr(evictAddr)
  );

  function automatic bit sameGran(logic [AW-1:0] a);
    return (a >> GL) == (mAddr >> GL);
  endfunction
  function automatic bit sameLine(logic [AW-1:0] a);
    return (a >> LL) == (mAddr >> LL);
  endfunction
  function automatic bit mKill();
    bit win = (mLeft > 0);
    bit remote = snpValid && snpInv && sameLine(snpAddr);
    if (!mValid) return 0;
    return trapValid || (evictValid && sameLine(evictAddr))
        || (stValid && sameGran(stAddr)) || (remote && !win) || (mPend && !win);
  endfunction
  function automatic bit mPass();
    return scValid && mValid && sameGran(scAddr) && !mKill();
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0; mPend = 0; mLeft = 0;
    end else if (lrValid && !trapValid) begin
      mValid = 1; mPend = 0; mLeft = DEF; mAddr = lrAddr;
    end else if (scValid || lrValid || mKill()) begin
      mValid = 0; mPend = 0; mLeft = 0;
    end else begin
      if (mValid && snpValid && snpInv && sameLine(snpAddr) && mLeft > 0) mPend = 1;
      if (mLeft > 0) mLeft--;
    end
  end

  task automatic chk(bit got, bit exp, string req, string what);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic idle();
    lrValid = 0; scValid = 0; stValid = 0; snpValid = 0; snpInv = 0;
    trapValid = 0; evictValid = 0;
    lrAddr = '0; scAddr = '0; stAddr = '0; snpAddr = '0; evictAddr = '0;
  endtask

  // entered just after a falling edge with inputs set
  task automatic tick();
    #3;
    if (rstN) begin
      chk(scPass, mPass(), curReq, "scPass vs model");
      chk(snpStall, mPend, curReq, "snpStall vs model");
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic doLr(logic [AW-1:0] a);
    lrValid = 1; lrAddr = a; tick();
  endtask

  task automatic doSc(logic [AW-1:0] a, bit exp, string req);
    curReq = req; scValid = 1; scAddr = a;
    #2 chk(scPass, exp, req, "store-conditional result");
    tick();
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1000;
  localparam logic [AW-1:0] AG = 32'h0000_1010;  // same line, other granule
  localparam logic [AW-1:0] B = 32'h0000_2040;   // other line

  initial begin
    #(20 * 200000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: run did not finish, all requirements unconfirmed");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk(snpStall, 0, "R11", "stall during reset");
    rstN = 1;

    // R11: nothing reserved after reset
    doSc(A, 0, "R11");

    // R1 R2 R3: basic pass, then reuse fails
    curReq = "R1"; doLr(A);
    doSc(A + 4, 1, "R2");
    doSc(A, 0, "R3");

    // R2 R3: wrong granule fails and still consumes
    doLr(A);
    doSc(AG, 0, "R2");
    doSc(A, 0, "R3");

    // R1: replacement
    doLr(A); doLr(B);
    doSc(B, 1, "R1");
    doLr(A); doLr(B);
    doSc(A, 0, "R1");

    // R5: remote load-reserved harmless, even after window
    curReq = "R5"; doLr(A);
    snpValid = 1; snpInv = 0; snpAddr = A; tick();
    wait_n(DEF + 2);
    snpValid = 1; snpInv = 0; snpAddr = A; tick();
    doSc(A, 1, "R5");

    // R4: hit on same line after window
    curReq = "R4"; doLr(A); wait_n(DEF + 1);
    snpValid = 1; snpInv = 1; snpAddr = AG; tick();
    doSc(A, 0, "R4");
    doLr(A); wait_n(DEF + 1);
    snpValid = 1; snpInv = 1; snpAddr = A;
    doSc(A, 0, "R4");
    doLr(A); wait_n(DEF + 1);
    snpValid = 1; snpInv = 1; snpAddr = B; tick();
    doSc(A, 1, "R4");

    // R6: local store
    curReq = "R6"; doLr(A);
    stValid = 1; stAddr = A + 8; tick();
    doSc(A, 0, "R6");
    doLr(A);
    stValid = 1; stAddr = AG; tick();
    doSc(A, 1, "R6");

    // R7: trap
    curReq = "R7"; doLr(A);
    trapValid = 1; tick();
    doSc(A, 0, "R7");
    lrValid = 1; lrAddr = A; trapValid = 1; tick();
    doSc(A, 0, "R7");

    // R8: eviction
    curReq = "R8"; doLr(A);
    evictValid = 1; evictAddr = AG; tick();
    doSc(A, 0, "R8");
    doLr(A);
    evictValid = 1; evictAddr = B; tick();
    doSc(A, 1, "R8");

    // R9: deferred hit keeps reservation, SC inside window passes
    curReq = "R9"; doLr(A);
    snpValid = 1; snpInv = 1; snpAddr = A; tick();
    #1 chk(snpStall, 1, "R9", "stall after deferred hit");
    #1; tick();
    doSc(A, 1, "R9");
    #1 chk(snpStall, 0, "R9", "stall after SC");

    // R10: stall length and release
    begin
      int stallCycles = 0;
      curReq = "R10"; doLr(A);
      snpValid = 1; snpInv = 1; snpAddr = A; tick();
      for (int i = 0; i < DEF + 4; i++) begin
        #1 if (snpStall) stallCycles++;
        tick();
      end
      checkCnt++;
      if (stallCycles != DEF) begin
        failCnt++;
        $display("FAIL R10 stall length: actual %0d expected %0d", stallCycles, DEF);
      end
      doSc(A, 0, "R10");
    end
    curReq = "R10"; doLr(A);
    snpValid = 1; snpInv = 1; snpAddr = AG; tick();
    wait_n(DEF - 1);
    doSc(A, 0, "R10");

    // R11: reset mid reservation
    doLr(A);
    rstN = 0; tick(); rstN = 1;
    doSc(A, 0, "R11");

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule